// File: doc/BRIEF.md
# Counterflow Convolution Array with Resident Weights

The block computes a sliding-window weighted sum over a stream of signed samples: for a window starting at sample m, the result is the sum over t of w_t times x_{m+t}, with t running over the K taps. It is a linear chain of K identical cells. Each cell keeps one tap weight for the whole run. Samples step through the chain one cell per cycle in one direction. Partial sums step one cell per cycle in the opposite direction and pick up one product in each cell they cross. A partial sum starts as a zero token at the far end of the chain. When it leaves the near end it is complete, so the path that carries the running sums also serves as the result output.

The K tap weights arrive one per beat on a serial load port. While loading, the array does not accept samples. Once the K-th weight is in, the block accepts a sample only on every second cycle. Samples therefore sit two cycles apart, and so do the partial sums, which is what lets every sum cross every sample. A slot with no sample becomes a bubble. Each partial sum carries a flag recording whether it met a real sample in every cell, and only sums that did are reported as results.

Top module: `counterflow_conv`

## Requirements
- R1: Weights are shifted in one per cycle while `w_valid` is high. The t-th weight loaded (t = 0 first) multiplies sample x_{m+t} of window m. In the cycle after the K-th beat of a load, `x_ready` is high.
- R2: From the cycle after the first beat of a load until the load completes, `x_ready` stays low. A beat that arrives while streaming starts a fresh load that needs K new beats.
- R3: While streaming, `x_ready` is high in streaming cycle 0 and in every even cycle after it, and low in every odd cycle. Streaming cycle 0 is the first cycle with `x_ready` high after a load. Sample slot j is the cycle 2j, and a sample is taken only when `x_valid` and `x_ready` are both high.
- R4: `y_data` is the full-precision signed sum over t of w_t·x_{m+t}. It is 8+8+log2(K) bits wide at the default widths and never overflows.
- R5: A result for window m is flagged with `y_valid` only if all K slots m..m+K-1 held a sample. Windows that touch a bubble produce no `y_valid`.
- R6: The result for window m appears in streaming cycle 2m+2K-1. This gives a fixed latency from the first sample and at most one result every two cycles.
- R7: After reset, `x_ready` and `y_valid` are low, and no sample is accepted until K weights have been loaded.
- R8: A reload discards all partial sums in flight. No result computed partly with old weights appears after the reload, and from the second cycle after the first reload beat `y_valid` is low until new results are due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| w_valid | input | 1 | Weight beat strobe |
| w_data | input | WW | Signed weight for the current beat |
| x_valid | input | 1 | Sample present in this cycle |
| x_data | input | XW | Signed sample |
| x_ready | output | 1 | Sample slot open in this cycle |
| y_valid | output | 1 | Completed window result present |
| y_data | output | XW+WW+log2(K) | Signed window result |

## Verification
The assertions assume that `x_valid` is raised only in cycles where `x_ready` is high. They also assume that weight beats are never interleaved with sample traffic. Under those inputs, sample and partial-sum tokens can never sit in adjacent cycles of any cell. The stimulus keeps within these limits: it drives samples only on even streaming cycles and holds `x_valid` low throughout every load. Bubbles are produced by randomly skipping a slot, which is always legal, and a reload is issued only after the sample drive has been withdrawn.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  function automatic int acc_width(input int xw, input int ww, input int taps);
    return xw + ww + $clog2(taps);
  endfunction

endpackage

// File: rtl/cwa_wload.sv
module cwa_wload #(
  parameter int K  = 4,
  parameter int WW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 w_valid,
  input  logic [WW-1:0]        w_data,
  output logic [K-1:0][WW-1:0] w_q,
  output logic                 run_q
);

  localparam int CW = $clog2(K + 1);

  logic [K-1:0][WW-1:0] w_nxt;
  logic [CW-1:0]        cnt_q, cnt_nxt;
  logic                 run_nxt;

  always_comb begin
    w_nxt   = w_q;
    cnt_nxt = cnt_q;
    run_nxt = run_q;
    if (w_valid) begin
      w_nxt = {w_q[K-2:0], w_data};
      if (run_q) begin
        cnt_nxt = CW'(1);
        run_nxt = 1'b0;
      end else begin
        cnt_nxt = cnt_q + CW'(1);
        run_nxt = (cnt_q == CW'(K - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      w_q   <= w_nxt;
      cnt_q <= cnt_nxt;
      run_q <= run_nxt;
    end
  end

  // R2: a beat during streaming must stop the stream
  a_r2_reload_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && run_q) |=> !run_q);

  // R1: streaming starts only right after a weight beat
  a_r1_run_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(w_valid));

endmodule

// File: rtl/cwa_cell.sv
module cwa_cell #(
  parameter int XW = 8,
  parameter int WW = 8,
  parameter int YW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic signed [WW-1:0] w,
  input  logic signed [XW-1:0] x_in,
  input  logic                 xv_in,
  input  logic signed [YW-1:0] y_in,
  input  logic                 yv_in,
  input  logic                 yc_in,
  output logic signed [XW-1:0] x_out,
  output logic                 xv_out,
  output logic signed [YW-1:0] y_out,
  output logic                 yv_out,
  output logic                 yc_out
);

  localparam int PW = XW + WW;

  logic signed [PW-1:0] prod;
  logic signed [YW-1:0] prod_ext;
  logic signed [YW-1:0] y_nxt;
  logic                 xv_nxt, yv_nxt, yc_nxt;

  always_comb begin
    prod     = w * x_in;
    prod_ext = {{(YW - PW){prod[PW-1]}}, prod};
    y_nxt    = xv_in ? (y_in + prod_ext) : y_in;
    xv_nxt   = xv_in & ~flush;
    yv_nxt   = yv_in & ~flush;
    yc_nxt   = yc_in & xv_in & ~flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_out  <= '0;
      xv_out <= 1'b0;
      y_out  <= '0;
      yv_out <= 1'b0;
      yc_out <= 1'b0;
    end else begin
      x_out  <= x_in;
      xv_out <= xv_nxt;
      y_out  <= y_nxt;
      yv_out <= yv_nxt;
      yc_out <= yc_nxt;
    end
  end

  // R3: samples travel two cycles apart through every cell
  a_r3_sample_gap: assert property (@(posedge clk) disable iff (!rst_n)
    xv_out |=> !xv_out);

  // R6: partial sums travel two cycles apart through every cell
  a_r6_sum_gap: assert property (@(posedge clk) disable iff (!rst_n)
    yv_out |=> !yv_out);

endmodule

// File: rtl/counterflow_conv.sv
module counterflow_conv #(
  parameter int K  = 4,
  parameter int XW = 8,
  parameter int WW = 8,
  parameter int YW = cwa_pkg::acc_width(XW, WW, K)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          w_valid,
  input  logic [WW-1:0] w_data,
  input  logic          x_valid,
  input  logic [XW-1:0] x_data,
  output logic          x_ready,
  output logic          y_valid,
  output logic [YW-1:0] y_data
);

  import cwa_pkg::*;

  localparam phase_e INJ_PH = phase_e'((K - 1) % 2);

  logic [K-1:0][WW-1:0] w_q;
  logic                 run_q;
  phase_e               ph_q, ph_nxt;
  logic                 inject;

  logic [K:0][XW-1:0] x_link;
  logic [K:0]         xv_link;
  logic [K:0][YW-1:0] y_link;
  logic [K:0]         yv_link;
  logic [K:0]         yc_link;

  cwa_wload #(.K(K), .WW(WW)) i_wload (
    .clk     (clk),
    .rst_n   (rst_n),
    .w_valid (w_valid),
    .w_data  (w_data),
    .w_q     (w_q),
    .run_q   (run_q)
  );

  always_comb begin
    ph_nxt = PH_EVEN;
    if (run_q) ph_nxt = (ph_q == PH_EVEN) ? PH_ODD : PH_EVEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_EVEN;
    else        ph_q <= ph_nxt;
  end

  always_comb begin
    x_ready    = run_q & (ph_q == PH_EVEN);
    inject     = run_q & (ph_q == INJ_PH);
    x_link[0]  = x_data;
    xv_link[0] = x_valid & x_ready;
    y_link[K]  = '0;
    yv_link[K] = inject;
    yc_link[K] = inject;
  end

  for (genvar i = 0; i < K; i++) begin : g_cell
    cwa_cell #(.XW(XW), .WW(WW), .YW(YW)) i_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (~run_q),
      .w      (w_q[i]),
      .x_in   (x_link[i]),
      .xv_in  (xv_link[i]),
      .y_in   (y_link[i+1]),
      .yv_in  (yv_link[i+1]),
      .yc_in  (yc_link[i+1]),
      .x_out  (x_link[i+1]),
      .xv_out (xv_link[i+1]),
      .y_out  (y_link[i]),
      .yv_out (yv_link[i]),
      .yc_out (yc_link[i])
    );
  end

  assign y_valid = yv_link[0] & yc_link[0];
  assign y_data  = y_link[0];

  // R3: samples only offered in open slots (input rule)
  a_r3_sample_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    x_valid |-> x_ready);

  // R6: results never on consecutive cycles
  a_r6_result_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |=> !y_valid);

  // R7: no result while weights are incomplete for two cycles running
  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && $past(!run_q)) |-> !y_valid);

endmodule

// File: tb/test_counterflow_conv.sv
module test_counterflow_conv;

  localparam int K  = 4;
  localparam int XW = 8;
  localparam int WW = 8;
  localparam int YW = XW + WW + $clog2(K);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          w_valid;
  logic [WW-1:0] w_data;
  logic          x_valid;
  logic [XW-1:0] x_data;
  logic          x_ready;
  logic          y_valid;
  logic [YW-1:0] y_data;

  int checks = 0;
  int errors = 0;
  int wts[K];
  int sx[64];
  bit sv[64];

  always #10 clk = ~clk;

  counterflow_conv #(.K(K), .XW(XW), .WW(WW)) i_counterflow_conv (
    .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .w_data(w_data),
    .x_valid(x_valid), .x_data(x_data), .x_ready(x_ready),
    .y_valid(y_valid), .y_data(y_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int window_sum(input int m);
    int s = 0;
    for (int t = 0; t < K; t++) s += wts[t] * sx[m+t];
    return s;
  endfunction

  function automatic bit window_full(input int m, input int n);
    if (m < 0 || m + K - 1 >= n) return 1'b0;
    for (int t = 0; t < K; t++) if (!sv[m+t]) return 1'b0;
    return 1'b1;
  endfunction

  // mode 0 directed, 1 random, 2 extreme negative
  task automatic load_weights(input int mode);
    for (int b = 0; b < K; b++) begin
      @(negedge clk);
      if (b >= 1) chk(x_ready == 1'b0, "R2 x_ready low while loading", int'(x_ready), 0);
      if (b >= 2) chk(y_valid == 1'b0, "R8 no stale result after reload", int'(y_valid), 0);
      case (mode)
        0:       wts[b] = b + 1;
        1:       wts[b] = int'($urandom % 256) - 128;
        default: wts[b] = -128;
      endcase
      w_valid = 1'b1;
      w_data  = WW'(wts[b]);
    end
    @(negedge clk);
    w_valid = 1'b0;
  endtask

  // mode 0 ramp, 1 random, 2 extreme; cut < 0 means run to drain
  task automatic run_stream(input int n, input int bub, input int mode, input int cut);
    for (int t = 0; t <= 2 * n + 2 * K; t++) begin
      int got, m;
      if (t > 0) @(negedge clk);
      if (t == 0) chk(x_ready == 1'b1, "R1 stream opens after last beat", int'(x_ready), 1);
      else        chk(x_ready == ((t % 2) == 0), "R3 alternate slots", int'(x_ready), int'((t % 2) == 0));
      m   = (t - 2 * K + 1) / 2;
      got = int'($signed(y_data));
      if (t >= 2 * K - 1 && ((t - 2 * K + 1) % 2) == 0 && window_full(m, n)) begin
        chk(y_valid == 1'b1, "R6 result at fixed cycle", int'(y_valid), 1);
        chk(got == window_sum(m), "R4 window sum", got, window_sum(m));
      end else begin
        chk(y_valid == 1'b0, "R5 no result for partial or bubble window", int'(y_valid), 0);
      end
      if (t == cut) begin
        x_valid = 1'b0;
        return;
      end
      x_valid = 1'b0;
      if ((t % 2) == 0 && t / 2 < n) begin
        int j = t / 2;
        sv[j] = (int'($urandom % 100) >= bub);
        case (mode)
          0:       sx[j] = j + 1;
          1:       sx[j] = int'($urandom % 256) - 128;
          default: sx[j] = (j % 3 == 0) ? 127 : -128;
        endcase
        x_valid = sv[j];
        x_data  = XW'(sx[j]);
      end
    end
    x_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; w_valid = 1'b0; w_data = '0; x_valid = 1'b0; x_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(x_ready == 1'b0, "R7 x_ready low after reset", int'(x_ready), 0);
    chk(y_valid == 1'b0, "R7 y_valid low after reset", int'(y_valid), 0);
    repeat (4) @(negedge clk);
    chk(x_ready == 1'b0, "R7 no stream without weights", int'(x_ready), 0);

    // R1 R4 directed taps and ramp, no bubbles
    load_weights(0);
    run_stream(12, 0, 0, -1);
    // R4 R5 random data with bubbles
    load_weights(1);
    run_stream(30, 20, 1, -1);
    // R4 extreme operands, full precision
    load_weights(2);
    run_stream(16, 0, 2, -1);
    // R2 R8 reload in the middle of a stream
    load_weights(1);
    run_stream(20, 0, 1, 14);
    load_weights(0);
    run_stream(14, 0, 1, -1);
    // R5 heavy bubbles
    load_weights(1);
    run_stream(30, 50, 1, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule